// File: doc/BRIEF.md
# Shared-Bus Concurrent Write Resolver

The block settles what a shared bus carries when several of its P ports write in the same request. Each port has a write-enable bit and a data word, and a two-bit rule code chosen per request picks how contention is handled. Under the common-value rule, writers that agree put their value on the bus. Under the collision rule, the bus only tells a reader whether more than one port wrote. Under the arbitrary rule, one writer is picked and the result stays valid whichever it is. Under the priority rule, the lowest-numbered writer wins. When the two writes clash, the bus carries a collision word of all ones and a collision flag is set. A request with no writers gives a zero bus and raises an idle flag.

The priority rule is not built as a flat priority encoder. The block reads the port index as digits in a configurable radix and makes one elimination pass per clock, starting at the most significant digit. In each pass, every surviving port raises a line for its own digit value. The smallest raised value is taken, and only the ports that carry it survive. All ports raising the same line drive the same value, so each pass is itself a valid common-value write. After the last digit exactly one port remains, and its data goes onto the bus. The other rules finish in one clock.

A request is issued by pulsing `start` while the block is not busy. The inputs are sampled on that edge. The result appears together with a one-cycle `done` pulse and holds until the next result.

Top module: `bus_write_resolver`

## Requirements
- R1: After reset, `done`, `busy`, `collision` and `idle` are 0, and `bus_data` and `winner` are 0.
- R2: A request with no write-enable set gives `bus_data`=0, `collision`=0, `idle`=1 and `winner`=0 under every rule code. It completes one clock edge after it is accepted.
- R3: Rule code 0 (common value): if every writing port drives the same word, the bus carries that word, `collision`=0, and `winner` is the lowest writing index.
- R4: Rule code 0: if two writing ports drive different words, the bus carries all ones, `collision`=1 and `winner`=0. Whenever `collision` is 1, the bus is all ones.
- R5: Rule code 1 (collision detect): with exactly one writer, the bus carries its word and `winner` is its index, with `collision`=0. With two or more writers, the bus carries all ones and `collision`=1, even if their words agree.
- R6: Rule code 2 (arbitrary): the bus carries the word of the highest-indexed writer, `winner` is that index, and `collision`=0.
- R7: Rule code 3 (priority): the bus carries the word of the lowest-indexed writer, `winner` is that index, and `collision`=0.
- R8: Rules 0 to 2 complete one clock edge after the accepting edge. Priority with writers completes DIGITS+1 edges after it, where DIGITS is the number of radix digits needed for index PORTS-1 (2 for 9 ports in radix 3). `done` is high for that one cycle only. The outputs hold their values until the next completion.
- R9: A `start` while `busy` is 1 is ignored, and the request in flight completes unchanged.
- R10: Each priority pass keeps a non-empty subset of the ports that survived the previous pass. After the last pass exactly one port survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accept a request when not busy |
| wr_en | input | PORTS | Write-enable, bit i belongs to port i |
| wr_data | input | PORTS*DATA_W | Write words, port i at bits [i*DATA_W +: DATA_W] |
| rule | input | 2 | 0 common, 1 collision, 2 arbitrary, 3 priority |
| busy | output | 1 | Priority elimination in progress |
| done | output | 1 | One-cycle result strobe |
| bus_data | output | DATA_W | Resolved bus word |
| collision | output | 1 | Contention reported |
| idle | output | 1 | No port wrote |
| winner | output | $clog2(PORTS) | Index of the port whose word is on the bus |

## Verification
The bench targets priority cases where the leading digit ties and only a lower digit decides. A sieve that stopped early or kept the wrong digit value would name the higher port there. It sends the same agreeing word from two ports under the collision rule, where a design that compared data would wrongly report no collision. It also sends a writer-less priority request, where a design that started the elimination anyway would take the wrong time or lose the idle flag. It issues a second `start` during a priority pass, which a design lacking the busy guard would accept, replacing the result in flight.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [1:0] {
        RULE_AGREE   = 2'd0,
        RULE_COLLIDE = 2'd1,
        RULE_ANY     = 2'd2,
        RULE_RANK    = 2'd3
    } rule_e;

    typedef enum logic {
        PH_WAIT  = 1'b0,
        PH_SIEVE = 1'b1
    } phase_e;

    // number of radix digits needed to write index ports-1
    function automatic int digits_for(input int ports, input int radix);
        int n;
        int span;
        n    = 1;
        span = radix;
        while (span < ports) begin
            span = span * radix;
            n    = n + 1;
        end
        return n;
    endfunction

    // digit at position pos of idx, written in base radix
    function automatic int digit_at(input int idx, input int pos, input int radix);
        int v;
        v = idx;
        for (int k = 0; k < pos; k++) begin
            v = v / radix;
        end
        return v % radix;
    endfunction

endpackage

// File: rtl/write_census.sv
module write_census #(
    parameter int PORTS  = 9,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic [PORTS-1:0]        en,
    input  logic [PORTS*DATA_W-1:0] data,
    output logic                    any_w,
    output logic                    multi_w,
    output logic [IDX_W-1:0]        lo_idx,
    output logic [IDX_W-1:0]        hi_idx,
    output logic                    agree
);

    logic             lo_found;
    logic [DATA_W-1:0] lo_word;

    always_comb begin
        lo_found = 1'b0;
        lo_idx   = '0;
        hi_idx   = '0;
        for (int p = 0; p < PORTS; p++) begin
            if (en[p]) begin
                if (!lo_found) begin
                    lo_idx   = IDX_W'(p);
                    lo_found = 1'b1;
                end
                hi_idx = IDX_W'(p);
            end
        end
        any_w   = |en;
        multi_w = $countones(en) > 1;
    end

    always_comb begin
        lo_word = '0;
        for (int p = 0; p < PORTS; p++) begin
            if (IDX_W'(p) == lo_idx) begin
                lo_word = data[p*DATA_W +: DATA_W];
            end
        end
        agree = 1'b1;
        for (int p = 0; p < PORTS; p++) begin
            if (en[p] && (data[p*DATA_W +: DATA_W] != lo_word)) begin
                agree = 1'b0;
            end
        end
    end

endmodule

// File: rtl/digit_sieve.sv
module digit_sieve
    import rsv_pkg::*;
#(
    parameter int PORTS = 9,
    parameter int RADIX = 3,
    parameter int POS   = 0
) (
    input  logic [PORTS-1:0] active,
    output logic [PORTS-1:0] keep
);

    logic [RADIX-1:0] raised;
    logic             seen;
    int               min_val;

    // every survivor raises the line of its own digit value
    always_comb begin
        raised = '0;
        for (int p = 0; p < PORTS; p++) begin
            if (active[p]) begin
                raised[digit_at(p, POS, RADIX)] = 1'b1;
            end
        end
    end

    // smallest raised line wins
    always_comb begin
        seen    = 1'b0;
        min_val = 0;
        for (int v = 0; v < RADIX; v++) begin
            if (raised[v] && !seen) begin
                min_val = v;
                seen    = 1'b1;
            end
        end
    end

    always_comb begin
        for (int p = 0; p < PORTS; p++) begin
            keep[p] = active[p] && (digit_at(p, POS, RADIX) == min_val);
        end
    end

endmodule

// File: rtl/bus_write_resolver.sv
module bus_write_resolver
    import rsv_pkg::*;
#(
    parameter int PORTS  = 9,
    parameter int RADIX  = 3,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [PORTS-1:0]              wr_en,
    input  logic [PORTS*DATA_W-1:0]       wr_data,
    input  logic [1:0]                    rule,
    output logic                          busy,
    output logic                          done,
    output logic [DATA_W-1:0]             bus_data,
    output logic                          collision,
    output logic                          idle,
    output logic [$clog2(PORTS)-1:0]      winner
);

    localparam int IDX_W  = $clog2(PORTS);
    localparam int DIGITS = digits_for(PORTS, RADIX);
    localparam int POS_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1;

    typedef struct packed {
        phase_e                  ph;
        logic [POS_W-1:0]        pos;
        logic [PORTS-1:0]        act;
        logic [PORTS*DATA_W-1:0] held;
        logic [1:0]              rule;
        logic                    done;
        logic [DATA_W-1:0]       bus;
        logic                    coll;
        logic                    idle;
        logic [IDX_W-1:0]        win;
    } state_t;

    state_t s_d, s_q;

    function automatic logic [DATA_W-1:0] pick_word(
        input logic [PORTS*DATA_W-1:0] words,
        input logic [IDX_W-1:0]        idx
    );
        logic [DATA_W-1:0] w;
        w = '0;
        for (int p = 0; p < PORTS; p++) begin
            if (IDX_W'(p) == idx) begin
                w = words[p*DATA_W +: DATA_W];
            end
        end
        return w;
    endfunction

    function automatic logic [IDX_W-1:0] first_set(input logic [PORTS-1:0] v);
        logic [IDX_W-1:0] i;
        logic             hit;
        i   = '0;
        hit = 1'b0;
        for (int p = 0; p < PORTS; p++) begin
            if (v[p] && !hit) begin
                i   = IDX_W'(p);
                hit = 1'b1;
            end
        end
        return i;
    endfunction

    // request census on the live inputs
    logic             c_any, c_multi, c_agree;
    logic [IDX_W-1:0] c_lo, c_hi;

    write_census #(
        .PORTS (PORTS),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) i_census (
        .en     (wr_en),
        .data   (wr_data),
        .any_w  (c_any),
        .multi_w(c_multi),
        .lo_idx (c_lo),
        .hi_idx (c_hi),
        .agree  (c_agree)
    );

    // one sieve per digit position, selected by the pass counter
    logic [PORTS-1:0] keep [DIGITS];

    for (genvar g = 0; g < DIGITS; g++) begin : g_sieve
        digit_sieve #(
            .PORTS(PORTS),
            .RADIX(RADIX),
            .POS  (g)
        ) i_sieve (
            .active(s_q.act),
            .keep  (keep[g])
        );
    end

    logic [PORTS-1:0] survivors;
    assign survivors = keep[s_q.pos];

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.ph)
            PH_WAIT: begin
                if (start) begin
                    s_d.rule = rule;
                    if ((rule == RULE_RANK) && c_any) begin
                        s_d.ph   = PH_SIEVE;
                        s_d.act  = wr_en;
                        s_d.held = wr_data;
                        s_d.pos  = POS_W'(DIGITS - 1);
                    end else begin
                        s_d.done = 1'b1;
                        s_d.coll = 1'b0;
                        s_d.idle = 1'b0;
                        s_d.win  = '0;
                        s_d.bus  = '0;
                        if (!c_any) begin
                            s_d.idle = 1'b1;
                        end else begin
                            case (rule_e'(rule))
                                RULE_AGREE: begin
                                    if (c_agree) begin
                                        s_d.bus = pick_word(wr_data, c_lo);
                                        s_d.win = c_lo;
                                    end else begin
                                        s_d.bus  = '1;
                                        s_d.coll = 1'b1;
                                    end
                                end
                                RULE_COLLIDE: begin
                                    if (c_multi) begin
                                        s_d.bus  = '1;
                                        s_d.coll = 1'b1;
                                    end else begin
                                        s_d.bus = pick_word(wr_data, c_lo);
                                        s_d.win = c_lo;
                                    end
                                end
                                default: begin
                                    s_d.bus = pick_word(wr_data, c_hi);
                                    s_d.win = c_hi;
                                end
                            endcase
                        end
                    end
                end
            end
            default: begin
                s_d.act = survivors;
                if (s_q.pos == '0) begin
                    s_d.ph   = PH_WAIT;
                    s_d.done = 1'b1;
                    s_d.coll = 1'b0;
                    s_d.idle = 1'b0;
                    s_d.win  = first_set(survivors);
                    s_d.bus  = pick_word(s_q.held, first_set(survivors));
                end else begin
                    s_d.pos = s_q.pos - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.ph == PH_SIEVE);
    assign done      = s_q.done;
    assign bus_data  = s_q.bus;
    assign collision = s_q.coll;
    assign idle      = s_q.idle;
    assign winner    = s_q.win;

    // collision word always accompanies the collision flag
    assert_coll_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.coll |-> (s_q.bus == {DATA_W{1'b1}}));

    // idle result is quiet
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.idle |-> ((s_q.bus == '0) && !s_q.coll && (s_q.win == '0)));

    // a pass never revives a port
    assert_sieve_subset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_SIEVE) && $past(s_q.ph == PH_SIEVE)
            |-> ((s_q.act & ~$past(s_q.act)) == '0));

    // the survivor set never empties
    assert_sieve_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_SIEVE) |-> (s_q.act != '0));

    // after the final pass exactly one survivor remains
    assert_single_survivor_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_SIEVE) && (s_q.pos == '0) |=> $onehot(s_q.act));

    // no result while the elimination runs
    assert_no_done_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // request in flight is not replaced
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_SIEVE) && $past(s_q.ph == PH_SIEVE)
            |-> ((s_q.rule == $past(s_q.rule)) && (s_q.held == $past(s_q.held))));

endmodule

// File: tb/test_bus_write_resolver.sv
`timescale 1ns/1ps
module test_bus_write_resolver;

    localparam int PORTS  = 9;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 4;

    logic                    clk;
    logic                    rst_n;
    logic                    start;
    logic [PORTS-1:0]        wr_en;
    logic [PORTS*DATA_W-1:0] wr_data;
    logic [1:0]              rule;
    logic                    busy, done, collision, idle;
    logic [DATA_W-1:0]       bus_data;
    logic [IDX_W-1:0]        winner;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;

    bus_write_resolver #(.PORTS(PORTS), .RADIX(3), .DATA_W(DATA_W)) i_bus_write_resolver (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .wr_data(wr_data),
        .rule(rule), .busy(busy), .done(done), .bus_data(bus_data),
        .collision(collision), .idle(idle), .winner(winner)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 20000);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    typedef struct packed {
        logic [1:0]        rl;
        logic [PORTS-1:0]  en;
        logic              same;
        logic [DATA_W-1:0] bus;
        logic              coll;
        logic              idl;
        logic [IDX_W-1:0]  win;
        logic [2:0]        lat;
    } vec_t;

    // same=1: every port drives 5C; same=0: port i drives 20+17*i
    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 9'b000010100, 1'b1, 8'h5C, 1'b0, 1'b0, 4'd2, 3'd1}, // R3
        '{2'd0, 9'b000010100, 1'b0, 8'hFF, 1'b1, 1'b0, 4'd0, 3'd1}, // R4
        '{2'd0, 9'b111111111, 1'b1, 8'h5C, 1'b0, 1'b0, 4'd0, 3'd1}, // R3
        '{2'd1, 9'b001000000, 1'b0, 8'h86, 1'b0, 1'b0, 4'd6, 3'd1}, // R5
        '{2'd1, 9'b100000001, 1'b1, 8'hFF, 1'b1, 1'b0, 4'd0, 3'd1}, // R5
        '{2'd2, 9'b010001010, 1'b0, 8'h97, 1'b0, 1'b0, 4'd7, 3'd1}, // R6
        '{2'd2, 9'b000000001, 1'b0, 8'h20, 1'b0, 1'b0, 4'd0, 3'd1}, // R6
        '{2'd3, 9'b110100000, 1'b0, 8'h75, 1'b0, 1'b0, 4'd5, 3'd3}, // R7 R10
        '{2'd3, 9'b100000000, 1'b0, 8'hA8, 1'b0, 1'b0, 4'd8, 3'd3}, // R7
        '{2'd3, 9'b111111111, 1'b0, 8'h20, 1'b0, 1'b0, 4'd0, 3'd3}, // R7
        '{2'd3, 9'b000011000, 1'b0, 8'h53, 1'b0, 1'b0, 4'd3, 3'd3}, // R10 low digit decides
        '{2'd3, 9'b000000000, 1'b0, 8'h00, 1'b0, 1'b1, 4'd0, 3'd1}, // R2
        '{2'd0, 9'b000000000, 1'b1, 8'h00, 1'b0, 1'b1, 4'd0, 3'd1}  // R2
    };

    function automatic logic [PORTS*DATA_W-1:0] words(input logic same);
        logic [PORTS*DATA_W-1:0] w;
        for (int i = 0; i < PORTS; i++) begin
            w[i*DATA_W +: DATA_W] = same ? 8'h5C : DATA_W'(8'h20 + 17 * i);
        end
        return w;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // issue a request at a falling edge and count edges to done
    task automatic issue(input logic [1:0] r, input logic [PORTS-1:0] e,
                         input logic same, output int n);
        @(negedge clk);
        rule    = r;
        wr_en   = e;
        wr_data = words(same);
        start   = 1'b1;
        n       = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            n     = n + 1;
        end while (!done && n < 10);
    endtask

    initial begin
        int n;
        logic [DATA_W-1:0] held_bus;
        rst_n   = 1'b0;
        start   = 1'b0;
        wr_en   = '0;
        wr_data = '0;
        rule    = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 done",      int'(done), 0);
        check("R1 busy",      int'(busy), 0);
        check("R1 bus",       int'(bus_data), 0);
        check("R1 collision", int'(collision), 0);
        check("R1 idle",      int'(idle), 0);
        check("R1 winner",    int'(winner), 0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            issue(TBL[k].rl, TBL[k].en, TBL[k].same, n);
            check($sformatf("R8 latency v%0d", k), n, int'(TBL[k].lat));
            check($sformatf("R3-7 bus v%0d", k), int'(bus_data), int'(TBL[k].bus));
            check($sformatf("R4 collision v%0d", k), int'(collision), int'(TBL[k].coll));
            check($sformatf("R2 idle v%0d", k), int'(idle), int'(TBL[k].idl));
            check($sformatf("R7 winner v%0d", k), int'(winner), int'(TBL[k].win));
        end

        // R8: done is a single pulse and the result holds
        held_bus = bus_data;
        repeat (2) @(negedge clk);
        check("R8 done dropped", int'(done), 0);
        issue(2'd2, 9'b010001010, 1'b0, n);
        held_bus = bus_data;
        repeat (3) @(negedge clk);
        check("R8 bus held", int'(bus_data), int'(held_bus));
        check("R8 winner held", int'(winner), 7);

        // R9: a start during the priority passes is ignored
        @(negedge clk);
        rule    = 2'd3;
        wr_en   = 9'b010000000;
        wr_data = words(1'b0);
        start   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9 busy", int'(busy), 1);
        rule    = 2'd0;
        wr_en   = 9'b111111111;
        wr_data = words(1'b1);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R9 still busy", int'(busy), 1);
        @(posedge clk);
        @(negedge clk);
        check("R9 done", int'(done), 1);
        check("R9 bus", int'(bus_data), 8'h97);
        check("R9 winner", int'(winner), 7);
        @(posedge clk);
        @(negedge clk);
        check("R9 no second result", int'(done), 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule